// File: doc/BRIEF.md
# Correctable ECC Error Address Log

This block keeps a short history of the memory locations at which a single-bit (correctable) ECC error was reported on one memory port. The ECC decoder next to the memory pulses a strobe with the failing address and a flag for whether the error was single-bit or double-bit. Single-bit reports at an address that is not already recorded go into a small table. Repeats of an address that is still recorded are dropped, and double-bit reports are ignored. Software reads the table through a plain register port. When it has dealt with an entry, it frees that entry by writing a one to the entry's top bit.

When every slot is occupied and a new single-bit error at an unrecorded address arrives, the table is left as it is. A sticky overflow flag is set instead, and it can drive an interrupt line through an enable bit. The table depth is a parameter; 4, 8 and 16 are typical. A memory with two read ports needs two independent instances, one per port, each 4 deep.

Register map (index on `reg_sel`): indices 0 to DEPTH-1 are the table entries. Index DEPTH is the status register, with the overflow flag in bit 0. Index DEPTH+1 is the interrupt-enable register, with the enable in bit 0. Any other index reads as zero. Reads are combinational. Writes and error reports take effect at the rising clock edge.

Top module: `sbe_addr_log`

## Requirements
- R1: An error report with `err_dbl`=1 creates no entry, changes no entry and does not touch the overflow flag.
- R2: A single-bit report whose address equals the address of an entry that is valid (after same-cycle clears) writes nothing and raises no overflow.
- R3: Reading entry i returns a word whose bit ADDR_W (the MSB) is the valid flag and whose bits ADDR_W-1:0 are the logged address. After reset, every entry reads as invalid.
- R4: A new, unique single-bit error is written to the lowest-indexed invalid entry and sets that entry's valid flag. It is readable on the cycle after the report.
- R5: Writing an entry with bit ADDR_W set clears that entry's valid flag so the entry can be reused. Writing an entry with bit ADDR_W clear has no effect.
- R6: A unique single-bit error while all entries are valid sets the overflow flag (status bit 0) and leaves every entry unchanged.
- R7: The overflow flag holds until software writes 1 to status bit 0; writing 0 there has no effect. If an overflow event and that clear fall in the same cycle, the flag stays set.
- R8: `irq` equals the overflow flag ANDed with the enable (bit 0 of register DEPTH+1), and the enable reads back as written. After reset, the flag, the enable and `irq` are 0.
- R9: A clear and a new error in the same cycle: the clear is applied first. The error may then take the entry just freed, including when the error carries the address that was just cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_stb | input | 1 | One-cycle error report from the ECC decoder |
| err_dbl | input | 1 | 1 = double-bit error, 0 = single-bit error |
| err_addr | input | ADDR_W | Memory address of the failing read |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | clog2(DEPTH+2) | Register index |
| reg_wdata | input | ADDR_W+1 | Register write data |
| reg_rdata | output | ADDR_W+1 | Register read data for `reg_sel` |
| irq | output | 1 | Overflow interrupt |

## Verification
The bound checker watches on every cycle that no two valid entries share an address, that double-bit reports and idle cycles leave the table alone, that a clear empties its entry, and that the overflow flag is set only by a single-bit report and stays set until it is cleared. Only the bench's scenarios can show which slot a new error lands in, what a read returns after each step, and the order in which the table fills. The same goes for the corner cases where a clear and an error fall in one cycle, and for how the enable gates the interrupt.

// File: rtl/sbe_addr_log.sv
module sbe_addr_log #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4,
  localparam int DW    = ADDR_W + 1,
  localparam int RA_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_stb,
  input  logic              err_dbl,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);

  localparam logic [RA_W-1:0] SEL_STAT = RA_W'(DEPTH);
  localparam logic [RA_W-1:0] SEL_IEN  = RA_W'(DEPTH + 1);

  logic [DEPTH-1:0]  valid_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic              ovf_q;
  logic              ien_q;

  logic [DEPTH-1:0]  clr_mask;
  logic [DEPTH-1:0]  vld_eff;
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  free_v;
  logic [DEPTH-1:0]  grant;
  logic              sbe, hit, full, take, ovf_evt, ovf_clr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign clr_mask[i] = reg_wr && (reg_sel == RA_W'(i)) && reg_wdata[DW-1];
    assign match[i]    = vld_eff[i] && (addr_q[i] == err_addr);
  end

  assign vld_eff = valid_q & ~clr_mask;
  assign free_v  = ~vld_eff;
  assign grant   = free_v & (~free_v + DEPTH'(1));

  assign sbe     = err_stb && !err_dbl;
  assign hit     = |match;
  assign full    = &vld_eff;
  assign take    = sbe && !hit && !full;
  assign ovf_evt = sbe && !hit && full;
  assign ovf_clr = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        addr_q[i]  <= '0;
      end else begin
        valid_q[i] <= vld_eff[i] | (take & grant[i]);
        if (take && grant[i]) addr_q[i] <= err_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (ovf_evt)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (reg_wr && reg_sel == SEL_IEN) ien_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (reg_sel == RA_W'(i)) reg_rdata = {valid_q[i], addr_q[i]};
    if (reg_sel == SEL_STAT) reg_rdata = {{(DW-1){1'b0}}, ovf_q};
    if (reg_sel == SEL_IEN)  reg_rdata = {{(DW-1){1'b0}}, ien_q};
  end

  assign irq = ovf_q & ien_q;

endmodule

// File: rtl/sbe_addr_log_chk.sv
module sbe_addr_log_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4,
  localparam int DW    = ADDR_W + 1,
  localparam int RA_W  = $clog2(DEPTH + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_stb,
  input logic              err_dbl,
  input logic              reg_wr,
  input logic [RA_W-1:0]   reg_sel,
  input logic [DW-1:0]     reg_wdata,
  input logic [DEPTH-1:0]  valid_q,
  input logic [ADDR_W-1:0] addr_q [DEPTH],
  input logic              ovf_q
);

  p_dbl_no_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb && err_dbl && !reg_wr |=> $stable(valid_q) && $stable(ovf_q));

  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_stb && !reg_wr |=> $stable(valid_q) && $stable(ovf_q));

  p_ovf_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(err_stb && !err_dbl));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(reg_wr && reg_sel == RA_W'(DEPTH) && reg_wdata[0]) |=> ovf_q);

  for (genvar i = 0; i < DEPTH; i++) begin : g_clr
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_sel == RA_W'(i) && reg_wdata[DW-1] && !(err_stb && !err_dbl)
      |=> !valid_q[i]);
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_pair
      p_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[i] && valid_q[j] |-> addr_q[i] != addr_q[j]);
    end
  end

endmodule

bind sbe_addr_log sbe_addr_log_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .err_dbl(err_dbl),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .valid_q(valid_q), .addr_q(addr_q), .ovf_q(ovf_q)
);

// File: tb/test_sbe_addr_log.sv
module test_sbe_addr_log;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 4;
  localparam int DW     = ADDR_W + 1;
  localparam int RA_W   = $clog2(DEPTH + 2);
  localparam logic [DW-1:0] VBIT = DW'(1) << ADDR_W;
  localparam logic [RA_W-1:0] STAT = RA_W'(DEPTH);
  localparam logic [RA_W-1:0] IEN  = RA_W'(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic err_stb = 0, err_dbl = 0;
  logic [ADDR_W-1:0] err_addr = '0;
  logic reg_wr = 0;
  logic [RA_W-1:0] reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  sbe_addr_log #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_sbe_addr_log (
    .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .err_dbl(err_dbl),
    .err_addr(err_addr), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    err_stb = 0; err_dbl = 0; reg_wr = 0;
  endtask

  task automatic report(logic [ADDR_W-1:0] a, logic dbl);
    err_stb = 1; err_dbl = dbl; err_addr = a; step();
  endtask

  task automatic wr(logic [RA_W-1:0] s, logic [DW-1:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d; step();
  endtask

  task automatic rd(logic [RA_W-1:0] s, output logic [DW-1:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(string req, logic [RA_W-1:0] s, logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(s, d); chk(req, d, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < DEPTH; i++) chk_reg("R3 reset entry", RA_W'(i), '0);
    chk_reg("R8 reset status", STAT, '0);
    chk_reg("R8 reset enable", IEN, '0);
    chk("R8 reset irq", DW'(irq), '0);
  endtask

  task automatic t_fill_order();
    report(12'h123, 0);
    chk_reg("R4 first to entry0", 0, VBIT | 13'h123);
    report(12'h045, 0);
    chk_reg("R4 second to entry1", 1, VBIT | 13'h045);
    chk_reg("R3 entry2 still empty", 2, '0);
  endtask

  task automatic t_dup();
    report(12'h123, 0);
    chk_reg("R2 dup not logged", 2, '0);
    chk_reg("R2 entry0 intact", 0, VBIT | 13'h123);
  endtask

  task automatic t_dbl();
    report(12'h777, 1);
    chk_reg("R1 double not logged", 2, '0);
    chk_reg("R1 status untouched", STAT, '0);
  endtask

  task automatic t_clear();
    logic [DW-1:0] d;
    wr(0, 13'h0fff);
    chk_reg("R5 write0 no effect", 0, VBIT | 13'h123);
    wr(0, VBIT);
    rd(0, d); chk("R5 cleared valid", DW'(d[DW-1]), '0);
    report(12'h200, 0);
    chk_reg("R4 reuse lowest free", 0, VBIT | 13'h200);
    report(12'h300, 0);
    report(12'h400, 0);
    chk_reg("R4 entry3 filled", 3, VBIT | 13'h400);
  endtask

  task automatic t_overflow();
    report(12'h500, 0);
    chk_reg("R6 overflow set", STAT, 13'h1);
    chk("R8 irq masked", DW'(irq), '0);
    chk_reg("R6 entry3 unchanged", 3, VBIT | 13'h400);
    chk_reg("R6 entry0 unchanged", 0, VBIT | 13'h200);
    wr(STAT, 13'h0);
    chk_reg("R7 write0 keeps flag", STAT, 13'h1);
    wr(STAT, 13'h1);
    chk_reg("R7 write1 clears", STAT, 13'h0);
    report(12'h300, 0);
    chk_reg("R2 dup when full no overflow", STAT, 13'h0);
  endtask

  task automatic t_irq();
    wr(IEN, 13'h1);
    chk_reg("R8 enable readback", IEN, 13'h1);
    chk("R8 no irq without flag", DW'(irq), '0);
    report(12'h600, 0);
    chk("R8 irq raised", DW'(irq), 13'h1);
    err_stb = 1; err_addr = 12'h700; reg_wr = 1; reg_sel = STAT; reg_wdata = 13'h1;
    step();
    chk_reg("R7 set wins over clear", STAT, 13'h1);
    wr(STAT, 13'h1);
    chk("R8 irq drops", DW'(irq), '0);
    wr(IEN, 13'h0);
  endtask

  task automatic t_same_cycle();
    err_stb = 1; err_addr = 12'h045; reg_wr = 1; reg_sel = 1; reg_wdata = VBIT;
    step();
    chk_reg("R9 same addr relogged", 1, VBIT | 13'h045);
    chk_reg("R9 no overflow", STAT, 13'h0);
    err_stb = 1; err_addr = 12'h999; reg_wr = 1; reg_sel = 2; reg_wdata = VBIT;
    step();
    chk_reg("R9 freed entry taken", 2, VBIT | 13'h999);
    chk_reg("R9 still no overflow", STAT, 13'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk); rst_n = 1;
    step();
    t_fill_order();
    t_dup();
    t_dbl();
    t_clear();
    t_overflow();
    t_irq();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule